// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a serial bit stream into a single line level. It supports seven line codings: plain level coding, two transition-on-value codings, two bi-phase space/mark codings, bi-phase level coding and its differential variant. A clock enable pulses twice per bit period. The first pulse of a bit samples the incoming bit and sets the level that opens the bit. The second pulse sets the level for the second half of the bit, which is how the mid-bit edges are produced.

When no bit is offered on the first pulse, the block sends a one in the selected coding, so the line carries idle ones. The coding may be changed only between bits, while the line is idle. Framing, flags, checksums and clock recovery are handled elsewhere.

The control is a two-state phase sequencer. PH_BEGIN waits for the pulse that opens a bit and, on that pulse, takes transition T_OPEN to PH_CENTER. PH_CENTER waits for the mid-bit pulse and, on it, takes transition T_CLOSE back to PH_BEGIN. Without a pulse, either state stays where it is. A rule decoder computes the opening level, the mid-bit level and the next remembered mid-edge direction for each coding.

Top module: `serial_line_encoder`

## Requirements
- R1: A synchronous reset drives the line low, returns the sequencer to PH_BEGIN and sets the remembered mid-bit edge direction to high-to-low.
- R2: Mode value 0 (and the spare value 7) is level coding: the line equals the bit for both halves.
- R3: Mode value 1: a one keeps the line level unchanged and a zero inverts it at the start of the bit, with no mid-bit change.
- R4: Mode value 2: a one inverts the line at the start of the bit and a zero keeps it, with no mid-bit change.
- R5: Mode value 3: every bit opens by inverting the line, and a zero adds a second inversion at mid-bit.
- R6: Mode value 4: every bit opens by inverting the line, and a one adds a second inversion at mid-bit.
- R7: Mode value 5: a one is high in the first half and low in the second, and a zero is low then high.
- R8: Mode value 6: a one makes the mid-bit edge the reverse of the previous such edge, and a zero repeats the previous direction. The first half is the opposite of the second. After reset the previous direction counts as high-to-low.
- R9: The line changes only in the cycle after a clock-enable pulse. The opening level appears after the PH_BEGIN pulse and the mid-bit level appears after the PH_CENTER pulse.
- R10: When the bit-valid input is low at the PH_BEGIN pulse, the bit is sent as a one, whatever the data input holds.
- R11: Data and bit-valid presented at the PH_CENTER pulse have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | Clock enable, two pulses per bit period |
| mode | input | 3 | Coding select (0..7) |
| bit_in | input | 1 | Data bit, sampled at the PH_BEGIN pulse |
| bit_valid | input | 1 | High when bit_in carries a real bit |
| line_out | output | 1 | Encoded line level |

## Verification
Each pulse of half_tick produces its result exactly one clock later. The opening level is due one cycle after the PH_BEGIN pulse, and the mid-bit level one cycle after the PH_CENTER pulse. The driver queues one expected level per pulse. The monitor notes at the rising edge which cycles carried a pulse and compares at the following falling edge. On every other falling edge it checks that the line still holds the last expected level. Gaps of varying length are placed between pulses, so that a line change without a pulse shows up as a mismatch.

// File: rtl/enc_pkg.sv
package enc_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_NRZ    = 3'd0,
        MODE_INV_Z  = 3'd1,
        MODE_INV_O  = 3'd2,
        MODE_BPS    = 3'd3,
        MODE_BPM    = 3'd4,
        MODE_BPL    = 3'd5,
        MODE_DBPL   = 3'd6,
        MODE_SPARE  = 3'd7
    } line_mode_e;

    typedef enum logic {
        PH_BEGIN  = 1'b0,
        PH_CENTER = 1'b1
    } half_e;

    // dir encoding: 0 = high-to-low mid edge, 1 = low-to-high mid edge
    typedef struct packed {
        logic open_lvl;
        logic mid_lvl;
        logic dir_next;
    } rule_t;
endpackage

// File: rtl/enc_phase_fsm.sv
module enc_phase_fsm
    import enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic half_tick,
    output logic at_begin
);
    half_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_BEGIN;
        else     state_q <= state_d;
    end

    // transitions T_OPEN and T_CLOSE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_BEGIN:  if (half_tick) state_d = PH_CENTER;
            PH_CENTER: if (half_tick) state_d = PH_BEGIN;
        endcase
    end

    // outputs
    always_comb begin
        at_begin = (state_q == PH_BEGIN);
    end
endmodule

// File: rtl/enc_rule.sv
module enc_rule
    import enc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              d,
    input  logic              cur_lvl,
    input  logic              prev_dir,
    output rule_t             rule
);
    logic dir_now;

    always_comb begin
        dir_now = d ? ~prev_dir : prev_dir;
        rule.dir_next = prev_dir;
        rule.open_lvl = d;
        rule.mid_lvl  = d;
        unique case (line_mode_e'(mode))
            MODE_NRZ, MODE_SPARE: begin
                rule.open_lvl = d;
                rule.mid_lvl  = d;
            end
            MODE_INV_Z: begin
                rule.open_lvl = d ? cur_lvl : ~cur_lvl;
                rule.mid_lvl  = rule.open_lvl;
            end
            MODE_INV_O: begin
                rule.open_lvl = d ? ~cur_lvl : cur_lvl;
                rule.mid_lvl  = rule.open_lvl;
            end
            MODE_BPS: begin
                rule.open_lvl = ~cur_lvl;
                rule.mid_lvl  = d ? ~cur_lvl : cur_lvl;
            end
            MODE_BPM: begin
                rule.open_lvl = ~cur_lvl;
                rule.mid_lvl  = d ? cur_lvl : ~cur_lvl;
            end
            MODE_BPL: begin
                rule.open_lvl = d;
                rule.mid_lvl  = ~d;
            end
            MODE_DBPL: begin
                rule.open_lvl = ~dir_now;
                rule.mid_lvl  = dir_now;
                rule.dir_next = dir_now;
            end
        endcase
    end
endmodule

// File: rtl/serial_line_encoder.sv
module serial_line_encoder
    import enc_pkg::*;
#(
    parameter logic IDLE_BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic [MODE_W-1:0] mode,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic              line_out
);
    logic  at_begin;
    logic  line_q, mid_q, dir_q;
    logic  d_eff;
    rule_t rule;

    enc_phase_fsm u_phase (
        .clk      (clk),
        .rst      (rst),
        .half_tick(half_tick),
        .at_begin (at_begin)
    );

    assign d_eff = bit_valid ? bit_in : IDLE_BIT;

    enc_rule u_rule (
        .mode    (mode),
        .d       (d_eff),
        .cur_lvl (line_q),
        .prev_dir(dir_q),
        .rule    (rule)
    );

    // line-state register
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            mid_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else if (half_tick) begin
            if (at_begin) begin
                line_q <= rule.open_lvl;
                mid_q  <= rule.mid_lvl;
                dir_q  <= rule.dir_next;
            end else begin
                line_q <= mid_q;
            end
        end
    end

    // outputs
    always_comb begin
        line_out = line_q;
    end
endmodule

// File: rtl/enc_line_chk.sv
module enc_line_chk
    import enc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              half_tick,
    input logic [MODE_W-1:0] mode,
    input logic              bit_in,
    input logic              bit_valid,
    input logic              at_begin,
    input logic              line_out
);
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !line_out);

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(line_out));

    assert_nrz_flat_mid_R2: assert property (@(posedge clk) disable iff (rst)
        (half_tick && !at_begin && (mode == 3'd0 || mode == 3'd7)) |=> $stable(line_out));

    assert_mark_one_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (half_tick && at_begin && mode == 3'd1 && bit_valid && bit_in) |=> $stable(line_out));

    assert_biphase_open_R5: assert property (@(posedge clk) disable iff (rst)
        (half_tick && at_begin && (mode == 3'd3 || mode == 3'd4)) |=> (line_out != $past(line_out)));

    assert_bpl_mid_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (half_tick && !at_begin && mode == 3'd5) |=> (line_out != $past(line_out)));

    assert_dbpl_mid_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (half_tick && !at_begin && mode == 3'd6) |=> (line_out != $past(line_out)));
endmodule

bind serial_line_encoder enc_line_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .half_tick(half_tick),
    .mode     (mode),
    .bit_in   (bit_in),
    .bit_valid(bit_valid),
    .at_begin (at_begin),
    .line_out (line_out)
);

// File: tb/serial_line_encoder_test.sv
`timescale 1ns/1ps
module serial_line_encoder_test;
    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_tick = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       line_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb[$];
    logic pend = 1'b0;
    logic hold_ref = 1'b0;
    logic armed = 1'b0;
    logic m_lvl, m_dir;
    int   gap = 0;

    always #4 clk = ~clk;  // 125 MHz

    serial_line_encoder uut (
        .clk(clk), .rst(rst), .half_tick(half_tick), .mode(mode),
        .bit_in(bit_in), .bit_valid(bit_valid), .line_out(line_out)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: line_out=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // monitor
    always @(posedge clk) pend <= half_tick && !rst;
    always @(negedge clk) begin
        if (armed && !rst) begin
            if (pend) begin
                exp_t e;
                if (sb.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9: line_out=%0b expected no result (queue empty)", line_out);
                end else begin
                    e = sb.pop_front();
                    check(line_out, e.lvl, e.tag);
                    hold_ref = e.lvl;
                end
            end else begin
                check(line_out, hold_ref, "R9 hold");
            end
        end
    end

    // reference behaviour written from the requirements
    task automatic model(input logic [2:0] m, input logic d,
                         output logic first_h, output logic second_h);
        logic dir;
        case (m)
            3'd1: begin first_h = d ? m_lvl : !m_lvl; second_h = first_h; end
            3'd2: begin first_h = d ? !m_lvl : m_lvl; second_h = first_h; end
            3'd3: begin first_h = !m_lvl; second_h = d ? first_h : !first_h; end
            3'd4: begin first_h = !m_lvl; second_h = d ? !first_h : first_h; end
            3'd5: begin first_h = d; second_h = !d; end
            3'd6: begin
                dir = d ? !m_dir : m_dir;   // 1 = rising mid edge
                m_dir = dir;
                second_h = dir; first_h = !dir;
            end
            default: begin first_h = d; second_h = d; end
        endcase
        m_lvl = second_h;
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        armed = 1'b0;
        rst = 1'b1; half_tick = 1'b0; mode = m;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lvl = 1'b0; m_dir = 1'b0; hold_ref = 1'b0;
        check(line_out, 1'b0, "R1 reset level");
        armed = 1'b1;
    endtask

    task automatic send_bit(input logic v, input logic b);
        logic f, s;
        exp_t e;
        string t;
        model(mode, v ? b : 1'b1, f, s);
        t = v ? mode_tag(mode) : {"R10/", mode_tag(mode)};
        @(negedge clk);
        half_tick = 1'b1; bit_valid = v; bit_in = b;
        e.lvl = f; e.tag = {t, " open"}; sb.push_back(e);
        @(negedge clk);
        half_tick = 1'b0;
        repeat (gap % 3) @(negedge clk);
        gap++;
        @(negedge clk);
        half_tick = 1'b1; bit_valid = !v; bit_in = !b;   // R11: ignored
        e.lvl = s; e.tag = {"R11/", t, " mid"}; sb.push_back(e);
        @(negedge clk);
        half_tick = 1'b0; bit_valid = 1'b0;
        repeat ((gap + 1) % 2) @(negedge clk);
    endtask

    logic [11:0] pattern = 12'b1001_1101_0011;

    initial begin
        for (int m = 0; m < 8; m++) begin
            do_reset(3'(m));
            for (int i = 0; i < 12; i++) send_bit(1'b1, pattern[i]);
            send_bit(1'b0, 1'b0);   // R10 idle
            send_bit(1'b0, 1'b1);
            send_bit(1'b1, 1'b0);
            send_bit(1'b1, 1'b0);
            repeat (3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9: watchdog expired, line_out=%0b expected completion", line_out);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule